// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides, cycle by cycle, whether a small 8-bit processor core should take an interrupt, and which source it should take. It handles two kinds of source. Event sources latch a pending flag when they pulse. Level sources request service only while their input is held high, and they keep no memory of it. Each source has its own enable bit. A global enable bit gates all of them. Software can clear pending event flags with a write-one-to-clear strobe.

The core tells the block when an instruction retires, when it accepts the offered interrupt, when it executes a return-from-interrupt, and when it executes a set-enable or a disable-interrupt operation. The block drives a request line and a binary vector index. The index names the highest-priority source that is both ready and enabled.

Taking an interrupt turns the global enable off. A handler can turn it back on to allow nesting. The return operation turns it on again. After a return, one foreground instruction must retire before the next interrupt can be accepted.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the global enable is 0, every event flag is 0, and `irqReq` is 0.
- R2: A pulse on an event source input sets that source's flag on the next clock edge, even when its own enable or the global enable is 0. The flag stays set until that source is accepted or software clears it.
- R3: When `flagClrWr` is 1, each event flag whose bit in `flagClrData` is 1 is cleared, and each flag whose bit is 0 is left unchanged. If a new event arrives for a source in the same cycle as its clear, the flag stays set.
- R4: `irqReq` is 1 only when the global enable is 1, no post-return hold-off is active, `cliStrobe` is 0, and at least one source is ready with its enable bit set. `irqVec` is the binary index of the lowest-numbered such source, and index 0 has the highest priority.
- R5: A cycle in which `accept` and `irqReq` are both 1 clears the global enable on the next edge. If the winner is an event source, that edge also clears its flag. `accept` has no effect while `irqReq` is 0.
- R6: Sources selected by `LEVEL_MASK` (default: indices 6 and 7) are ready only while their input is 1. A pulse that ends before the source is enabled leaves nothing pending. Accepting a level source clears nothing.
- R7: `gieSet` sets the global enable, including inside a handler. Any enabled ready source can then raise `irqReq` again, which allows nesting.
- R8: `retiStrobe` sets the global enable and starts a hold-off. While the hold-off is active, `irqReq` stays 0. The first `instrRetire` pulse in a later cycle ends the hold-off.
- R9: `cliStrobe` forces `irqReq` to 0 in its own cycle and clears the global enable on the next edge. It wins over `gieSet` and `retiStrobe` in the same cycle.
- R10: When several flags are pending as interrupts become enabled, they are offered one at a time, from the lowest index to the highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Event pulses (event sources) or held conditions (level sources) |
| srcEnable | input | NUM_SRC | Per-source enable bits |
| flagClrWr | input | 1 | Write strobe for the flag clear |
| flagClrData | input | NUM_SRC | Write-one-to-clear mask for event flags |
| gieSet | input | 1 | Core executed the set-global-enable operation |
| cliStrobe | input | 1 | Core executed the disable-interrupt operation |
| retiStrobe | input | 1 | Core executed the return-from-interrupt operation |
| instrRetire | input | 1 | A foreground instruction completed |
| accept | input | 1 | Core takes the offered interrupt this cycle |
| irqReq | output | 1 | An interrupt is offered |
| irqVec | output | $clog2(NUM_SRC) | Index of the winning source |
| gieOut | output | 1 | Current global enable |
| flagsOut | output | NUM_SRC | Event flags (level bits read 0) |

## Verification
Two collisions can fall in the same clock cycle.

The first is a software flag clear and a new event on the same source. The bench drives `flagClrWr` with a mask and pulses `srcIn` on one of the masked bits in the same cycle. It then reads `flagsOut` after the edge and expects that bit to stay set while the other masked bits clear.

The second is a disable-interrupt and an acceptance. The bench raises `cliStrobe` and `accept` together while a request is offered. It expects `irqReq` to drop at once, the global enable to clear, and the pending flag to survive, because the acceptance was refused.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeIrq;   // interrupt accepted this cycle
    logic reqOpen;   // global gating allows a request
  } ctlStrobe_t;

endpackage

// File: rtl/irq_flag_path.sv
module irq_flag_path
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               flagClrWr,
  input  logic [NUM_SRC-1:0] flagClrData,
  input  ctlStrobe_t         strobe,
  output logic [NUM_SRC-1:0] flagsOut,
  output logic               anyReady,
  output logic [IDXW-1:0]    winVec
);

  localparam logic [NUM_SRC-1:0] EDGE_MASK = ~LEVEL_MASK;

  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] readyVec;
  logic [NUM_SRC-1:0] candVec;
  logic [NUM_SRC-1:0] winHot;

  // One storage cell per source; level sources get no latch
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (LEVEL_MASK[g]) begin : g_level
      assign flagQ[g]    = 1'b0;
      assign readyVec[g] = srcIn[g];
    end else begin : g_event
      logic cellQ;
      logic clrHit;
      assign clrHit = (flagClrWr && flagClrData[g]) ||
                      (strobe.takeIrq && winHot[g]);
      always_ff @(posedge clk) begin
        if (!rstN)            cellQ <= 1'b0;
        else if (srcIn[g])    cellQ <= 1'b1;   // new event wins over clear
        else if (clrHit)      cellQ <= 1'b0;
      end
      assign flagQ[g]    = cellQ;
      assign readyVec[g] = cellQ;
    end
  end

  assign candVec = readyVec & srcEnable;
  assign anyReady = |candVec;

  // Lowest index wins
  always_comb begin
    winVec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (candVec[i]) winVec = IDXW'(i);
    end
  end

  always_comb begin
    winHot = '0;
    if (anyReady) winHot[winVec] = 1'b1;
  end

  assign flagsOut = flagQ & EDGE_MASK;

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gieSet,
  input  logic       cliStrobe,
  input  logic       retiStrobe,
  input  logic       instrRetire,
  input  logic       accept,
  input  logic       anyReady,
  output ctlStrobe_t strobe,
  output logic       irqReq,
  output logic       gieOut
);

  logic gieQ;
  logic holdQ;   // one foreground instruction still owed after a return

  assign strobe.reqOpen = gieQ && !holdQ && !cliStrobe;
  assign irqReq         = strobe.reqOpen && anyReady;
  assign strobe.takeIrq = accept && irqReq;

  always_ff @(posedge clk) begin
    if (!rstN)                               gieQ <= 1'b0;
    else if (strobe.takeIrq || cliStrobe)    gieQ <= 1'b0;
    else if (retiStrobe || gieSet)           gieQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            holdQ <= 1'b0;
    else if (retiStrobe)  holdQ <= 1'b1;
    else if (instrRetire) holdQ <= 1'b0;
  end

  assign gieOut = gieQ;

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0,
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               flagClrWr,
  input  logic [NUM_SRC-1:0] flagClrData,
  input  logic               gieSet,
  input  logic               cliStrobe,
  input  logic               retiStrobe,
  input  logic               instrRetire,
  input  logic               accept,
  output logic               irqReq,
  output logic [IDXW-1:0]    irqVec,
  output logic               gieOut,
  output logic [NUM_SRC-1:0] flagsOut
);

  ctlStrobe_t strobe;
  logic       anyReady;

  irq_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .gieSet(gieSet), .cliStrobe(cliStrobe),
    .retiStrobe(retiStrobe), .instrRetire(instrRetire), .accept(accept),
    .anyReady(anyReady), .strobe(strobe), .irqReq(irqReq), .gieOut(gieOut)
  );

  irq_flag_path #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_path (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .srcEnable(srcEnable),
    .flagClrWr(flagClrWr), .flagClrData(flagClrData), .strobe(strobe),
    .flagsOut(flagsOut), .anyReady(anyReady), .winVec(irqVec)
  );

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0,
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic [NUM_SRC-1:0] srcEnable,
  input logic               flagClrWr,
  input logic [NUM_SRC-1:0] flagClrData,
  input logic               gieSet,
  input logic               cliStrobe,
  input logic               retiStrobe,
  input logic               accept,
  input logic               irqReq,
  input logic [IDXW-1:0]    irqVec,
  input logic               gieOut,
  input logic [NUM_SRC-1:0] flagsOut
);

  localparam logic [NUM_SRC-1:0] EDGE_MASK = ~LEVEL_MASK;

  // R2
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((srcIn & EDGE_MASK) != '0) |=>
      ((flagsOut & $past(srcIn & EDGE_MASK)) == $past(srcIn & EDGE_MASK)));

  // R3
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagClrWr |=> ((flagsOut & $past(flagClrData & ~srcIn)) == '0));

  // R4
  req_needs_enables_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (gieOut && srcEnable[irqVec]));

  // R5
  accept_masks_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && irqReq) |=> !gieOut);

  // R8
  reti_holdoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    retiStrobe |=> !irqReq);

  // R9
  cli_blocks_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    cliStrobe |-> !irqReq);

  // R9
  cli_clears_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    cliStrobe |=> !gieOut);

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .srcIn(srcIn), .srcEnable(srcEnable),
  .flagClrWr(flagClrWr), .flagClrData(flagClrData), .gieSet(gieSet),
  .cliStrobe(cliStrobe), .retiStrobe(retiStrobe), .accept(accept),
  .irqReq(irqReq), .irqVec(irqVec), .gieOut(gieOut), .flagsOut(flagsOut)
);

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;

  localparam int N = 8;
  localparam logic [N-1:0] LVL = 8'hC0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] srcIn = '0, srcEnable = '0, flagClrData = '0;
  logic flagClrWr = 0, gieSet = 0, cliStrobe = 0, retiStrobe = 0;
  logic instrRetire = 0, accept = 0;
  logic irqReq, gieOut;
  logic [2:0] irqVec;
  logic [N-1:0] flagsOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(N), .LEVEL_MASK(LVL)) dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .srcEnable(srcEnable),
    .flagClrWr(flagClrWr), .flagClrData(flagClrData), .gieSet(gieSet),
    .cliStrobe(cliStrobe), .retiStrobe(retiStrobe), .instrRetire(instrRetire),
    .accept(accept), .irqReq(irqReq), .irqVec(irqVec), .gieOut(gieOut),
    .flagsOut(flagsOut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply one clock edge, then release pulses; level inputs stay held
  task automatic tick();
    @(posedge clk); #1;
    srcIn = srcIn & LVL;
    flagClrWr = 0; flagClrData = '0; gieSet = 0; cliStrobe = 0;
    retiStrobe = 0; instrRetire = 0; accept = 0;
    #1;
  endtask

  task automatic cleanup();
    srcIn = '0; flagClrWr = 1; flagClrData = '1; cliStrobe = 1; instrRetire = 1;
    tick();
    srcEnable = '0;
  endtask

  task automatic t_reset();
    chk("R1 gie", 32'(gieOut), 0);
    chk("R1 flags", 32'(flagsOut), 0);
    chk("R1 req", 32'(irqReq), 0);
  endtask

  task automatic t_latch_masked();
    srcIn = 8'h12; tick();
    chk("R2 flags set while masked", 32'(flagsOut), 32'h12);
    chk("R2 no req while masked", 32'(irqReq), 0);
    srcEnable = 8'h02; #1;
    chk("R4 no req without global enable", 32'(irqReq), 0);
    tick(); tick();
    chk("R2 flags held", 32'(flagsOut), 32'h12);
    cleanup();
  endtask

  task automatic t_clear();
    srcIn = 8'h15; tick();
    flagClrWr = 1; flagClrData = 8'h05; srcIn = 8'h01; tick();
    chk("R3 clear vs event", 32'(flagsOut), 32'h11);
    flagClrWr = 1; flagClrData = 8'h00; tick();
    chk("R3 zero bits no effect", 32'(flagsOut), 32'h11);
    cleanup();
  endtask

  task automatic t_priority_serve();
    srcEnable = '1;
    srcIn = 8'h28; tick();
    srcIn = 8'h02; tick();
    chk("R10 pending before enable", 32'(irqReq), 0);
    gieSet = 1; tick();
    chk("R7 gie set", 32'(gieOut), 1);
    chk("R4 req", 32'(irqReq), 1);
    chk("R10 first vec", 32'(irqVec), 1);
    accept = 1; tick();
    chk("R5 gie cleared", 32'(gieOut), 0);
    chk("R5 winner flag cleared", 32'(flagsOut), 32'h28);
    chk("R5 no req in handler", 32'(irqReq), 0);
    retiStrobe = 1; instrRetire = 1; tick();
    chk("R8 gie restored", 32'(gieOut), 1);
    chk("R8 held off after return", 32'(irqReq), 0);
    instrRetire = 1; tick();
    chk("R8 req after one retire", 32'(irqReq), 1);
    chk("R10 second vec", 32'(irqVec), 3);
    accept = 1; tick();
    retiStrobe = 1; tick();
    instrRetire = 1; tick();
    chk("R10 third vec", 32'(irqVec), 5);
    chk("R10 third req", 32'(irqReq), 1);
    cleanup();
  endtask

  task automatic t_accept_idle();
    srcEnable = '1; gieSet = 1; tick();
    accept = 1; tick();
    chk("R5 accept without req ignored", 32'(gieOut), 1);
    cleanup();
  endtask

  task automatic t_nest();
    srcEnable = '1; srcIn = 8'h20; gieSet = 1; tick();
    accept = 1; tick();
    srcIn = 8'h04; tick();
    chk("R7 masked in handler", 32'(irqReq), 0);
    gieSet = 1; tick();
    chk("R7 nested req", 32'(irqReq), 1);
    chk("R7 nested vec", 32'(irqVec), 2);
    cleanup();
  endtask

  task automatic t_level();
    srcEnable = 8'h00; srcIn = 8'h40; tick();
    srcIn = 8'h00; srcEnable = 8'h40; gieSet = 1; tick();
    chk("R6 lost level pulse", 32'(irqReq), 0);
    chk("R6 no latched flag", 32'(flagsOut), 0);
    srcIn = 8'h40; #1;
    chk("R6 level req", 32'(irqReq), 1);
    chk("R6 level vec", 32'(irqVec), 6);
    accept = 1; tick();
    retiStrobe = 1; tick();
    instrRetire = 1; tick();
    chk("R6 level not cleared by accept", 32'(irqReq), 1);
    srcIn = 8'h00; #1;
    chk("R6 level drops", 32'(irqReq), 0);
    cleanup();
  endtask

  task automatic t_cli();
    srcEnable = '1; srcIn = 8'h08; gieSet = 1; tick();
    chk("R9 req before", 32'(irqReq), 1);
    cliStrobe = 1; accept = 1; #1;
    chk("R9 req blocked same cycle", 32'(irqReq), 0);
    tick();
    chk("R9 gie cleared", 32'(gieOut), 0);
    chk("R9 flag survives refused accept", 32'(flagsOut), 32'h08);
    cliStrobe = 1; gieSet = 1; tick();
    chk("R9 wins over set", 32'(gieOut), 0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rstN = 1; #1;
    t_reset();
    t_latch_masked();
    t_clear();
    t_priority_serve();
    t_accept_idle();
    t_nest();
    t_level();
    t_cli();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule